// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

The receiver turns a three-wire stereo audio stream (bit clock, word-select clock and serial data) into parallel left and right samples. All three wires are oversampled by the system clock. The block finds the rising edges of the bit clock, and at each rising edge it takes in one data bit and one word-select level. A change in word-select level closes the current channel word. A one-cycle strobe marks each completed left/right pair.

The framing is set by a 3-bit strap code. There are seven framings: I2S, left-justified MSB-first, right-justified LSB-first with a 24-bit word, and right-justified MSB-first with a 24-, 20-, 18- or 16-bit word. In combined mode, a strap code of all zeros hands the choice to a control register, which comes in on a plain input port and uses the same encoding. The register's reset value (zero) means I2S. Every sample leaves the block sign-extended to 24 bits.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is low and `left_o` and `right_o` are zero until the first pair completes.
- R2: In pin mode, strap code 000 or 111 selects I2S. In I2S the sample MSB is the bit taken at the second bit-clock rise after a word-select change, and word-select low carries the left channel.
- R3: Strap code 001 selects left-justified. In this framing the MSB is the bit taken at the first bit-clock rise after a word-select change, and word-select high carries the left channel.
- R4: Strap code 010 selects right-justified LSB-first. The last 24 bits before the next word-select change form the sample, and the earliest of those 24 bits is bit 0. Word-select high carries the left channel.
- R5: Strap codes 011, 100, 101 and 110 select right-justified MSB-first with word lengths of 24, 20, 18 and 16 bits. The last N bits before the next word-select change form the sample, which is sign-extended to 24 bits. Word-select high carries the left channel.
- R6: In combined mode with strap 000, the register code selects the framing, using the same encoding as the strap. Register codes 000 and 111 select I2S, so the register's reset value gives I2S.
- R7: A nonzero strap code wins over the register in combined mode, and in pin mode the register has no effect.
- R8: `valid_o` goes high for exactly one cycle when a right-channel word closes after a left-channel word. `left_o` and `right_o` then hold that pair until the next pulse.
- R9: In I2S and left-justified framing, only the first 24 bits from the MSB position are kept, and later bits in the slot are ignored. If the slot holds fewer bits than that, the missing low bits are zero.
- R10: The word in progress when the first word-select change after reset is seen is discarded. A right-channel word with no left word before it produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word-select (left/right) clock |
| sdata_i | input | 1 | Serial data |
| combined_i | input | 1 | 1 = combined mode (register used when strap is 000), 0 = pin mode |
| strap_i | input | 3 | Format strap code |
| reg_fmt_i | input | 3 | Format code held by the control register |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle pulse for a new stereo pair |

## Verification
A wrong resolved format or a wrong left polarity shows up as swapped or bit-reversed samples at the first pulse after the stream starts. That is about two word slots after reset. A bit counter or capture position that is off by one shifts every sample by one bit, so the next pair differs from the arithmetic expectation. The bench checks every strap code and every register code against expected values computed in the bench. These include slots with filler bits set to ones, which catch a window that is too wide. A bad pairing state shows at the ports as a missing or extra pulse, or as a pulse two cycles wide, and the bench counts pulses for each run.

// File: rtl/audio_rx_pkg.sv
`timescale 1ns/1ps
package audio_rx_pkg;

    localparam int LEN_W = 6;

    typedef enum logic [1:0] {
        FMT_I2S       = 2'd0,
        FMT_LEFT      = 2'd1,
        FMT_RIGHT_LSB = 2'd2,
        FMT_RIGHT_MSB = 2'd3
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e      kind;
        logic [LEN_W-1:0] rj_len;
    } fmt_cfg_t;

    localparam logic [2:0] CODE_STD      = 3'd0;
    localparam logic [2:0] CODE_LEFT     = 3'd1;
    localparam logic [2:0] CODE_RLSB     = 3'd2;
    localparam logic [2:0] CODE_RMSB_A   = 3'd3;
    localparam logic [2:0] CODE_RMSB_B   = 3'd4;
    localparam logic [2:0] CODE_RMSB_C   = 3'd5;
    localparam logic [2:0] CODE_RMSB_D   = 3'd6;

endpackage

// File: rtl/audio_fmt_resolve.sv
`timescale 1ns/1ps
module audio_fmt_resolve
    import audio_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int RJ_LEN_A = 24,
    parameter int RJ_LEN_B = 20,
    parameter int RJ_LEN_C = 18,
    parameter int RJ_LEN_D = 16
) (
    input  logic       combined_i,
    input  logic [2:0] strap_i,
    input  logic [2:0] reg_fmt_i,
    output fmt_cfg_t   cfg_o
);

    logic [2:0] sel_code;

    always_comb begin
        // Register only takes over when combined mode is on and straps are all low.
        if (combined_i && (strap_i == CODE_STD)) begin
            sel_code = reg_fmt_i;
        end else begin
            sel_code = strap_i;
        end
    end

    always_comb begin
        cfg_o.kind   = FMT_I2S;
        cfg_o.rj_len = LEN_W'(SAMPLE_W);
        case (sel_code)
            CODE_LEFT:   cfg_o.kind = FMT_LEFT;
            CODE_RLSB:   cfg_o.kind = FMT_RIGHT_LSB;
            CODE_RMSB_A: begin cfg_o.kind = FMT_RIGHT_MSB; cfg_o.rj_len = LEN_W'(RJ_LEN_A); end
            CODE_RMSB_B: begin cfg_o.kind = FMT_RIGHT_MSB; cfg_o.rj_len = LEN_W'(RJ_LEN_B); end
            CODE_RMSB_C: begin cfg_o.kind = FMT_RIGHT_MSB; cfg_o.rj_len = LEN_W'(RJ_LEN_C); end
            CODE_RMSB_D: begin cfg_o.kind = FMT_RIGHT_MSB; cfg_o.rj_len = LEN_W'(RJ_LEN_D); end
            default:     cfg_o.kind = FMT_I2S;  // 000 and reserved 111
        endcase
    end

endmodule

// File: rtl/audio_edge_sync.sv
`timescale 1ns/1ps
module audio_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrck_i,
    input  logic sdata_i,
    output logic rise_o,
    output logic lr_o,
    output logic sd_o
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] bclk_sh;
        logic [SYNC_STAGES-1:0] lrck_sh;
        logic [SYNC_STAGES-1:0] data_sh;
        logic                   bclk_last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_comb begin
                st_d           = st_q;
                st_d.bclk_sh   = bclk_i;
                st_d.lrck_sh   = lrck_i;
                st_d.data_sh   = sdata_i;
                st_d.bclk_last = st_q.bclk_sh[TOP];
            end
        end else begin : g_chain
            always_comb begin
                st_d           = st_q;
                st_d.bclk_sh   = {st_q.bclk_sh[SYNC_STAGES-2:0], bclk_i};
                st_d.lrck_sh   = {st_q.lrck_sh[SYNC_STAGES-2:0], lrck_i};
                st_d.data_sh   = {st_q.data_sh[SYNC_STAGES-2:0], sdata_i};
                st_d.bclk_last = st_q.bclk_sh[TOP];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.bclk_sh[TOP] & ~st_q.bclk_last;
    assign lr_o   = st_q.lrck_sh[TOP];
    assign sd_o   = st_q.data_sh[TOP];

    // A detected rise needs a low sample first, so two rises never touch.
    assert_rise_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/audio_word_capture.sv
`timescale 1ns/1ps
module audio_word_capture
    import audio_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                lr_i,
    input  logic                sd_i,
    input  fmt_cfg_t            cfg_i,
    output logic                done_o,
    output logic                done_lr_o,
    output logic [SAMPLE_W-1:0] sample_o
);

    typedef struct packed {
        logic                primed;
        logic                word_ok;
        logic                lr_prev;
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] acc;
        logic [SAMPLE_W-1:0] sh;
        logic                done;
        logic                done_lr;
        logic [SAMPLE_W-1:0] sample;
    } cap_st_t;

    cap_st_t st_d, st_q;

    logic [SAMPLE_W-1:0] word_fmt;
    logic                rj_sign;
    int                  delay;
    int                  pos;

    // Build the finished word from the current accumulators.
    always_comb begin
        rj_sign  = 1'b0;
        word_fmt = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (i == int'(cfg_i.rj_len) - 1) rj_sign = st_q.sh[i];
        end
        case (cfg_i.kind)
            FMT_RIGHT_LSB: begin
                for (int i = 0; i < SAMPLE_W; i++) word_fmt[i] = st_q.sh[SAMPLE_W-1-i];
            end
            FMT_RIGHT_MSB: begin
                for (int i = 0; i < SAMPLE_W; i++)
                    word_fmt[i] = (i < int'(cfg_i.rj_len)) ? st_q.sh[i] : rj_sign;
            end
            default: word_fmt = st_q.acc;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        delay     = (cfg_i.kind == FMT_I2S) ? 1 : 0;
        pos       = int'(st_q.cnt) - delay;
        if (rise_i) begin
            if (!st_q.primed) begin
                st_d.primed  = 1'b1;
                st_d.lr_prev = lr_i;
            end else if (lr_i != st_q.lr_prev) begin
                if (st_q.word_ok) begin
                    st_d.done    = 1'b1;
                    st_d.done_lr = st_q.lr_prev;
                    st_d.sample  = word_fmt;
                end
                st_d.word_ok = 1'b1;
                st_d.lr_prev = lr_i;
                st_d.cnt     = CNT_W'(1);
                st_d.sh      = {{(SAMPLE_W-1){1'b0}}, sd_i};
                st_d.acc     = '0;
                if (delay == 0) st_d.acc[SAMPLE_W-1] = sd_i;
            end else begin
                st_d.sh  = {st_q.sh[SAMPLE_W-2:0], sd_i};
                st_d.cnt = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + 1'b1;
                for (int i = 0; i < SAMPLE_W; i++) begin
                    if (pos == i) st_d.acc[SAMPLE_W-1-i] = sd_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign done_lr_o = st_q.done_lr;
    assign sample_o  = st_q.sample;

    // Bit position counter saturates in long slots instead of wrapping.
    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && st_q.primed && (lr_i == st_q.lr_prev) && (st_q.cnt == '1))
        |=> (st_q.cnt == '1));

    // A finished word only ever follows a bit-clock rise.
    assert_done_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rise_i));

    // The first word-select change after reset never completes a word.
    assert_first_word_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !st_q.word_ok) |=> !done_o);

endmodule

// File: rtl/audio_frame_pair.sv
`timescale 1ns/1ps
module audio_frame_pair #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  logic                done_lr_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                left_high_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold;
        logic                have_left;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic     is_left;

    assign is_left = (done_lr_i == left_high_i);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (done_i) begin
            if (is_left) begin
                st_d.hold      = sample_i;
                st_d.have_left = 1'b1;
            end else if (st_q.have_left) begin
                st_d.left      = st_q.hold;
                st_d.right     = sample_i;
                st_d.valid     = 1'b1;
                st_d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign left_o  = st_q.left;
    assign right_o = st_q.right;
    assign valid_o = st_q.valid;

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_after_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(done_i && (done_lr_i != left_high_i)));

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (!valid_o || 1'b1) && ($stable(left_o) || valid_o));

endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
    import audio_rx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2,
    parameter int RJ_LEN_A    = 24,
    parameter int RJ_LEN_B    = 20,
    parameter int RJ_LEN_C    = 18,
    parameter int RJ_LEN_D    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrck_i,
    input  logic                sdata_i,
    input  logic                combined_i,
    input  logic [2:0]          strap_i,
    input  logic [2:0]          reg_fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    fmt_cfg_t            cfg;
    logic                bit_rise;
    logic                lr_s;
    logic                sd_s;
    logic                word_done;
    logic                word_lr;
    logic [SAMPLE_W-1:0] word_sample;
    logic                left_high;

    audio_fmt_resolve #(
        .SAMPLE_W (SAMPLE_W),
        .RJ_LEN_A (RJ_LEN_A),
        .RJ_LEN_B (RJ_LEN_B),
        .RJ_LEN_C (RJ_LEN_C),
        .RJ_LEN_D (RJ_LEN_D)
    ) u_resolve (
        .combined_i (combined_i),
        .strap_i    (strap_i),
        .reg_fmt_i  (reg_fmt_i),
        .cfg_o      (cfg)
    );

    audio_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk_i),
        .lrck_i  (lrck_i),
        .sdata_i (sdata_i),
        .rise_o  (bit_rise),
        .lr_o    (lr_s),
        .sd_o    (sd_s)
    );

    audio_word_capture #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (bit_rise),
        .lr_i      (lr_s),
        .sd_i      (sd_s),
        .cfg_i     (cfg),
        .done_o    (word_done),
        .done_lr_o (word_lr),
        .sample_o  (word_sample)
    );

    // I2S carries left on word-select low, all other framings on high.
    assign left_high = (cfg.kind != FMT_I2S);

    audio_frame_pair #(
        .SAMPLE_W (SAMPLE_W)
    ) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (word_done),
        .done_lr_i   (word_lr),
        .sample_i    (word_sample),
        .left_high_i (left_high),
        .left_o      (left_o),
        .right_o     (right_o),
        .valid_o     (valid_o)
    );

    assert_pin_i2s_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!combined_i && ((strap_i == 3'd0) || (strap_i == 3'd7))) |-> (cfg.kind == FMT_I2S));

    assert_combined_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (combined_i && (strap_i == 3'd0) && (reg_fmt_i == 3'd1)) |-> (cfg.kind == FMT_LEFT));

    assert_strap_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_i == 3'd2) |-> (cfg.kind == FMT_RIGHT_LSB));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !valid_o);

endmodule

// File: tb/audio_serial_rx_test.sv
`timescale 1ns/1ps
module audio_serial_rx_test;

    localparam int NF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic        combined = 1'b0;
    logic [2:0]  strap = 3'd0;
    logic [2:0]  regf = 3'd0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int n_cmp = 0;
    int n_bad = 0;
    int rx_idx = 0;
    bit checking = 1'b0;
    bit prev_valid = 1'b0;
    string cur_req = "R2";
    logic [23:0] exp_l [0:NF-1];
    logic [23:0] exp_r [0:NF-1];
    logic [23:0] raw_l [0:NF-1];
    logic [23:0] raw_r [0:NF-1];

    always #2.5 clk = ~clk;

    audio_serial_rx uut (
        .clk (clk), .rst_n (rst_n), .bclk_i (bclk), .lrck_i (lrck), .sdata_i (sdata),
        .combined_i (combined), .strap_i (strap), .reg_fmt_i (regf),
        .left_o (left_o), .right_o (right_o), .valid_o (valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic int eff_code(input bit comb, input logic [2:0] s, input logic [2:0] r);
        logic [2:0] c;
        c = (comb && s == 3'd0) ? r : s;
        return (c == 3'd7) ? 0 : int'(c);
    endfunction

    function automatic int rj_len(input int code);
        case (code)
            3: return 24;
            4: return 20;
            5: return 18;
            6: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic bitval(input int code, input int slot, input int j, input logic [23:0] raw);
        int k, n;
        if (code <= 1) begin
            k = j - ((code == 0) ? 1 : 0);
            return (k >= 0 && k < 24) ? raw[23-k] : 1'b1;
        end else if (code == 2) begin
            return (j >= slot - 24) ? raw[j-(slot-24)] : 1'b1;
        end
        n = rj_len(code);
        return (j >= slot - n) ? raw[n-1-(j-(slot-n))] : 1'b1;
    endfunction

    function automatic logic [23:0] expect_of(input int code, input int slot, input logic [23:0] raw);
        logic [23:0] e;
        int d, n;
        e = '0;
        if (code <= 1) begin
            d = (code == 0) ? 1 : 0;
            for (int k = 0; k < 24; k++) e[23-k] = (k < slot - d) ? raw[23-k] : 1'b0;
        end else if (code == 2) begin
            e = raw;
        end else begin
            n = rj_len(code);
            for (int i = 0; i < 24; i++) e[i] = (i < n) ? raw[i] : raw[n-1];
        end
        return e;
    endfunction

    task automatic send_bit(input logic lr, input logic b);
        @(negedge clk);
        lrck = lr;
        sdata = b;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic run_cfg(input bit comb, input logic [2:0] s, input logic [2:0] r,
                           input int slot, input int tag, input string req);
        int code;
        logic lv;
        code = eff_code(comb, s, r);
        lv = (code == 0) ? 1'b0 : 1'b1;
        cur_req = req;
        for (int k = 0; k < NF; k++) begin
            raw_l[k] = 24'(32'h00A5C3F1 * (k + 1) + tag * 32'h00135799);
            raw_r[k] = ~raw_l[k] ^ 24'(k * 32'h0000F00F);
            exp_l[k] = expect_of(code, slot, raw_l[k]);
            exp_r[k] = expect_of(code, slot, raw_r[k]);
        end
        @(negedge clk);
        rst_n = 1'b0;
        combined = comb;
        strap = s;
        regf = r;
        lrck = ~lv;
        bclk = 1'b0;
        sdata = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rx_idx = 0;
        checking = 1'b1;
        for (int j = 0; j < slot; j++) send_bit(~lv, 1'b1);      // dropped word, R10
        for (int k = 0; k < NF; k++) begin
            for (int j = 0; j < slot; j++) send_bit(lv, bitval(code, slot, j, raw_l[k]));
            for (int j = 0; j < slot; j++) send_bit(~lv, bitval(code, slot, j, raw_r[k]));
        end
        for (int j = 0; j < 4; j++) send_bit(lv, 1'b0);
        repeat (20) @(negedge clk);
        checking = 1'b0;
        check(rx_idx == NF, "R10", "pair count", 24'(rx_idx), 24'(NF));
        check(left_o == exp_l[NF-1], "R8", "left held after last pulse", left_o, exp_l[NF-1]);
    endtask

    always @(negedge clk) begin
        if (checking && rst_n) begin
            if (valid_o && prev_valid)
                check(1'b0, "R8", "pulse longer than one cycle", 24'(1), 24'(0));
            if (valid_o) begin
                if (rx_idx < NF) begin
                    check(left_o == exp_l[rx_idx], cur_req, "left sample", left_o, exp_l[rx_idx]);
                    check(right_o == exp_r[rx_idx], cur_req, "right sample", right_o, exp_r[rx_idx]);
                end else begin
                    check(1'b0, "R10", "extra pair", 24'(rx_idx), 24'(NF));
                end
                rx_idx++;
            end
        end
        prev_valid = valid_o;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid in reset", 24'(valid_o), 24'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid after reset", 24'(valid_o), 24'(0));
        check(left_o == 24'd0, "R1", "left after reset", left_o, 24'd0);
        check(right_o == 24'd0, "R1", "right after reset", right_o, 24'd0);
        // Pin mode: every strap code (R2 for 000/111, R3, R4, R5).
        run_cfg(1'b0, 3'd0, 3'd0, 32, 1, "R2");
        run_cfg(1'b0, 3'd7, 3'd0, 32, 2, "R2");
        run_cfg(1'b0, 3'd1, 3'd0, 32, 3, "R3");
        run_cfg(1'b0, 3'd2, 3'd0, 32, 4, "R4");
        for (int c = 3; c <= 6; c++) run_cfg(1'b0, 3'(c), 3'd0, 32, 4 + c, "R5");
        // Combined mode, straps low: every register code (R6).
        for (int c = 0; c < 8; c++) run_cfg(1'b1, 3'd0, 3'(c), 32, 20 + c, "R6");
        // Strap wins over register; register ignored in pin mode (R7).
        run_cfg(1'b1, 3'd3, 3'd1, 32, 30, "R7");
        run_cfg(1'b0, 3'd0, 3'd5, 32, 31, "R7");
        // Short and exact slots (R9, R5).
        run_cfg(1'b0, 3'd1, 3'd0, 20, 32, "R9");
        run_cfg(1'b0, 3'd0, 3'd0, 24, 33, "R9");
        run_cfg(1'b0, 3'd6, 3'd0, 16, 34, "R5");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule